// File: doc/BRIEF.md
# Serial Transmit Front End with Threshold-Driven Empty Flag

This block is the transmit side of an asynchronous serial port. Software fills a byte-wide FIFO through a small register bus, and a shift register takes bytes from that FIFO and sends them on a single line. Each byte goes out as a framed character: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Bit boundaries come from a baud tick pulse that is supplied from outside. A control register enables the transmitter and the transmit interrupt, and it also holds the enable bits that the receive side uses.

A status flag tells software that the FIFO needs refilling. The flag rises whenever the fill level is below a programmable trigger count. Software can clear it only with two steps: it reads the flag while the flag is 1, and it then writes 0 to it. The clear takes effect only when the FIFO holds more bytes than the trigger count at that moment. The interrupt output is high while the flag is set and the interrupt enable is on. A transmit-end status bit shows that the line has gone quiet and no data is waiting.

Top module: `sertx_core`

## Requirements
- R1: After reset the control and FIFO control registers read 0, the status register reads 3 (empty flag in bit 0 and transmit-end in bit 1 both set), `txd` is 1 and `tx_irq` is 0.
- R2: The control register (address 0) keeps bits 7, 6, 5, 4, 3, 1 and 0 as written. Bits 15 to 8 and bit 2 always read 0.
- R3: The FIFO holds 16 bytes, and software writes them at address 3. A write made while 16 bytes are waiting is discarded, so 17 writes with the transmitter off produce exactly the first 16 bytes on the line.
- R4: The trigger count is chosen by bits 1:0 of the FIFO control register (address 2), with 0, 1, 2 and 3 selecting 0, 2, 4 and 8 bytes. The empty flag (status bit 0, address 1) becomes 1 whenever the fill count is below the trigger count.
- R5: A write of 0 to status bit 0 has no effect unless the flag was read as 1 since the last write to the status register.
- R6: A write of 0 to status bit 0 that follows a read of 1 clears the flag only if the fill count is greater than the trigger count. When the count is equal to or below the trigger count, the flag is left as it was. Writing 1 never changes the flag.
- R7: `tx_irq` is 1 exactly while the empty flag is 1 and control bit 7 is 1. Clearing bit 7 drops `tx_irq` and leaves the flag unchanged.
- R8: Each byte is sent as a 0 start bit, eight data bits LSB first and a 1 stop bit. Each bit holds for one baud-tick period and changes at the clock edge where `baud_tick` is high.
- R9: While control bit 5 (transmitter enable) is 0, `txd` stays 1 and no byte leaves the FIFO. Bytes written during that time are sent once the bit is set.
- R10: Status bit 1 (transmit-end) goes to 0 when a byte is accepted into the FIFO. It returns to 1 when a stop bit finishes and the FIFO is empty.
- R11: Bytes that are already waiting go out back to back, and the start bit of each byte follows the previous stop bit with no idle period between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 FIFO control, 3 transmit data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (data address reads 0) |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| txd | output | 1 | Serial output line, idle high |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench runs through every trigger setting and every fill count from empty to full. At each point it attempts a flag clear, first without the required read and then with it. This exposes a design that clears without the read, one that compares with greater-or-equal instead of strictly greater, and one that decodes the trigger field wrongly. It also exposes a design that fails to set the flag again as the FIFO drains below the trigger. Every burst is decoded from the line against the bytes that were written. This catches a swapped bit order, a missing stop bit, bits that last longer or shorter than one tick, and idle gaps between bytes that were already queued. Separate runs cover the overflow write, the disabled transmitter, and a drop of the interrupt enable. These catch a FIFO that wraps over old data, a shifter that pops bytes while disabled, and an interrupt that outlives its enable bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_FCTL = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  localparam int CB_TIE  = 7;
  localparam int CB_RIE  = 6;
  localparam int CB_TE   = 5;
  localparam int CB_RE   = 4;
  localparam int CB_REIE = 3;

  localparam logic [15:0] CTRL_WMASK = 16'h00FB;

  localparam int SB_EMPTY = 0;
  localparam int SB_TEND  = 1;

  // trigger select 0,1,2,3 -> 0,2,4,8 bytes
  function automatic int trig_of(input logic [1:0] sel);
    return (sel == 2'd0) ? 0 : (1 << sel);
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    if (push_ok && !pop_ok)      cnt_d = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  assign pop_data = mem[rp_q];
  assign count    = cnt_q;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int DW  = 8,
  localparam int FW  = DW + 2,
  localparam int BCW = $clog2(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          baud_tick,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          pop,
  output logic          frame_end,
  output logic          txd
);

  logic           busy_q, busy_d;
  logic [FW-1:0]  sh_q, sh_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic           last_bit;

  assign last_bit = (bit_q == BCW'(FW - 1));

  always_comb begin
    busy_d    = busy_q;
    sh_d      = sh_q;
    bit_d     = bit_q;
    pop       = 1'b0;
    frame_end = 1'b0;
    if (!enable) begin
      busy_d    = 1'b0;
      sh_d      = '1;
      bit_d     = '0;
      frame_end = busy_q;
    end else if (baud_tick) begin
      if (busy_q && !last_bit) begin
        sh_d  = {1'b1, sh_q[FW-1:1]};
        bit_d = bit_q + BCW'(1);
      end else if (!fifo_empty) begin
        pop    = 1'b1;
        busy_d = 1'b1;
        sh_d   = {1'b1, fifo_data, 1'b0};
        bit_d  = '0;
      end else begin
        busy_d    = 1'b0;
        sh_d      = '1;
        bit_d     = '0;
        frame_end = busy_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
    end
  end

  assign txd = sh_q[0];

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig_lvl,
  input  logic          fifo_empty,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic          wr_flag_bit,
  input  logic          push_acc,
  input  logic          frame_end,
  output logic          empty_flag,
  output logic          tx_end,
  output logic          armed
);

  logic flag_q, flag_d;
  logic tend_q, tend_d;
  logic arm_q, arm_d;
  logic clear_ok;

  assign clear_ok = stat_wr && !wr_flag_bit && arm_q && (count > trig_lvl);

  always_comb begin
    flag_d = flag_q;
    if (clear_ok)         flag_d = 1'b0;
    if (count < trig_lvl) flag_d = 1'b1;

    arm_d = arm_q;
    if (stat_wr)                arm_d = 1'b0;
    else if (stat_rd && flag_q) arm_d = 1'b1;

    tend_d = tend_q;
    if (push_acc)                    tend_d = 1'b0;
    else if (frame_end && fifo_empty) tend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
      tend_q <= 1'b1;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      tend_q <= tend_d;
      arm_q  <= arm_d;
    end
  end

  assign empty_flag = flag_q;
  assign tx_end     = tend_q;
  assign armed      = arm_q;

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        baud_tick,
  output logic        txd,
  output logic        tx_irq
);

  reg_addr_e     addr_e;
  logic [15:0]   ctrl_q, ctrl_d;
  logic [1:0]    fctl_q, fctl_d;
  logic          wr_ctrl, wr_fctl, wr_stat, wr_data, rd_stat;
  logic          fifo_full, fifo_empty, fifo_pop, push_acc, frame_end;
  logic [DW-1:0] fifo_dout;
  logic [CW-1:0] fifo_cnt, trig_lvl;
  logic          empty_flag, tx_end, stat_armed;

  assign addr_e  = reg_addr_e'(bus_addr);
  assign wr_ctrl = bus_en && bus_we && (addr_e == A_CTRL);
  assign wr_stat = bus_en && bus_we && (addr_e == A_STAT);
  assign wr_fctl = bus_en && bus_we && (addr_e == A_FCTL);
  assign wr_data = bus_en && bus_we && (addr_e == A_DATA);
  assign rd_stat = bus_en && !bus_we && (addr_e == A_STAT);

  always_comb begin
    ctrl_d = wr_ctrl ? (bus_wdata & CTRL_WMASK) : ctrl_q;
    fctl_d = wr_fctl ? bus_wdata[1:0] : fctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fctl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      fctl_q <= fctl_d;
    end
  end

  assign trig_lvl = CW'(trig_of(fctl_q));
  assign push_acc = wr_data && !fifo_full;

  sertx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_data),
    .push_data (bus_wdata[DW-1:0]),
    .pop       (fifo_pop),
    .pop_data  (fifo_dout),
    .count     (fifo_cnt),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  sertx_shifter #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ctrl_q[CB_TE]),
    .baud_tick  (baud_tick),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_dout),
    .pop        (fifo_pop),
    .frame_end  (frame_end),
    .txd        (txd)
  );

  sertx_flags #(.CW(CW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (fifo_cnt),
    .trig_lvl    (trig_lvl),
    .fifo_empty  (fifo_empty),
    .stat_rd     (rd_stat),
    .stat_wr     (wr_stat),
    .wr_flag_bit (bus_wdata[SB_EMPTY]),
    .push_acc    (push_acc),
    .frame_end   (frame_end),
    .empty_flag  (empty_flag),
    .tx_end      (tx_end),
    .armed       (stat_armed)
  );

  always_comb begin
    bus_rdata = '0;
    case (addr_e)
      A_CTRL: bus_rdata = ctrl_q;
      A_STAT: begin
        bus_rdata[SB_EMPTY] = empty_flag;
        bus_rdata[SB_TEND]  = tx_end;
      end
      A_FCTL: bus_rdata[1:0] = fctl_q;
      default: bus_rdata = '0;
    endcase
  end

  assign tx_irq = empty_flag && ctrl_q[CB_TIE];

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk #(
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [15:0]   bus_rdata,
  input logic          txd,
  input logic          tx_irq,
  input logic          te,
  input logic          tie,
  input logic [CW-1:0] count,
  input logic [CW-1:0] trig_lvl,
  input logic          empty_flag,
  input logic          armed
);

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 2'd0) |-> (bus_rdata[15:8] == 8'h00 && !bus_rdata[2]));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_set_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count < trig_lvl) |=> empty_flag);

  p_clear_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_flag) |-> $past(armed));

  p_clear_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_flag) |-> ($past(count) > $past(trig_lvl)));

  p_tie_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tie) |-> !tx_irq);

  p_idle_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && $past(!te)) |-> txd);

  p_no_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !te |=> (count >= $past(count)));

endmodule

bind sertx_core sertx_core_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .txd        (txd),
  .tx_irq     (tx_irq),
  .te         (ctrl_q[5]),
  .tie        (ctrl_q[7]),
  .count      (fifo_cnt),
  .trig_lvl   (trig_lvl),
  .empty_flag (empty_flag),
  .armed      (stat_armed)
);

// File: tb/sertx_core_test.sv
`timescale 1ns/1ps
module sertx_core_test;

  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        baud_tick;
  logic        txd, tx_irq;

  int n_chk  = 0;
  int n_fail = 0;

  sertx_core uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .txd(txd), .tx_irq(tx_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // tick every 4 cycles; line decoder samples once per bit period
  int       ph = 0;
  int       rx_state = 0;
  int       idle_cnt = 0;
  int       gap_bad = 0;
  int       frame_err = 0;
  bit       rx_first = 1'b1;
  logic [7:0] rx_sh = '0;
  logic [7:0] rx_q[$];

  always @(negedge clk) begin
    if (ph == 2) begin
      if (rx_state == 0) begin
        if (txd === 1'b0) begin
          if (!rx_first && idle_cnt != 0) gap_bad++;
          rx_first = 1'b0;
          rx_state = 1;
        end else idle_cnt++;
      end else if (rx_state <= 8) begin
        rx_sh = {txd, rx_sh[7:1]};
        rx_state++;
      end else begin
        if (txd !== 1'b1) frame_err++;
        rx_q.push_back(rx_sh);
        rx_state = 0;
        idle_cnt = 0;
      end
    end
    ph = (ph + 1) % 4;
    baud_tick = (ph == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // enable transmitter, poll transmit-end, then disable and disarm
  task automatic drain(output int first_tend, output int done);
    logic [15:0] s;
    wr(2'd0, 16'h00A0);
    done = 0;
    first_tend = -1;
    for (int k = 0; k < 3000 && done == 0; k++) begin
      rd(2'd1, s);
      if (first_tend < 0) first_tend = int'(s[1]);
      if (s[1]) done = 1;
    end
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'h0001);
  endtask

  function automatic logic [7:0] pat(input int t, input int n, input int i);
    return 8'((t * 53) + (n * 11) + (i * 29) + 8'h5A);
  endfunction

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] s;
    int mflag, trig, ft, dn, gb0;
    bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; baud_tick = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, s); check("R1 ctrl", int'(s), 0);
    rd(2'd2, s); check("R1 fifo ctrl", int'(s), 0);
    rd(2'd1, s); check("R1 status", int'(s), 3);
    check("R1 txd", int'(txd), 1);
    check("R1 irq", int'(tx_irq), 0);
    wr(2'd1, 16'h0001);

    // R2 writable bit mask
    for (int b = 0; b < 16; b++) begin
      wr(2'd0, 16'(1 << b));
      rd(2'd0, s);
      check($sformatf("R2 bit %0d", b), int'(s), (1 << b) & 16'h00FB);
    end
    wr(2'd0, 16'h0000);

    // R7 interrupt enable gating
    wr(2'd0, 16'h0080);
    check("R7 irq with enable", int'(tx_irq), 1);
    wr(2'd0, 16'h0000);
    check("R7 irq after enable cleared", int'(tx_irq), 0);
    rd(2'd1, s);
    check("R7 flag kept", int'(s[0]), 1);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0080);

    // trigger x fill-count sweep: R4 R5 R6 R8 R10 R11
    mflag = 1;
    for (int t = 0; t < 4; t++) begin
      trig = (t == 0) ? 0 : (1 << t);
      wr(2'd2, 16'(t));
      if (trig > 0) mflag = 1;
      for (int n = 0; n <= 16; n++) begin
        rx_q.delete();
        rx_first = 1'b1;
        gb0 = gap_bad;
        for (int i = 0; i < n; i++) wr(2'd3, {8'h00, pat(t, n, i)});
        if (n < trig) mflag = 1;
        repeat (2) @(negedge clk);
        check($sformatf("R7 irq t%0d n%0d", t, n), int'(tx_irq), mflag);
        wr(2'd1, 16'h0000);
        rd(2'd1, s);
        check($sformatf("R5 R4 unarmed clear t%0d n%0d", t, n), int'(s[0]), mflag);
        wr(2'd1, 16'h0000);
        if (mflag == 1 && n > trig) mflag = 0;
        rd(2'd1, s);
        check($sformatf("R6 armed clear t%0d n%0d", t, n), int'(s[0]), mflag);
        drain(ft, dn);
        check($sformatf("R10 end reached t%0d n%0d", t, n), dn, 1);
        if (n > 0) check($sformatf("R10 end low t%0d n%0d", t, n), ft, 0);
        if (trig > 0) mflag = 1;
        check($sformatf("R8 frame count t%0d n%0d", t, n), rx_q.size(), n);
        for (int i = 0; i < n && i < rx_q.size(); i++)
          check($sformatf("R8 byte t%0d n%0d i%0d", t, n, i), int'(rx_q[i]), int'(pat(t, n, i)));
        check($sformatf("R11 gaps t%0d n%0d", t, n), gap_bad - gb0, 0);
      end
    end
    check("R8 stop bits", frame_err, 0);

    // R3 overflow write discarded
    rx_q.delete(); rx_first = 1'b1;
    for (int i = 0; i < 17; i++) wr(2'd3, 16'(8'h40 + i));
    drain(ft, dn);
    check("R3 frames", rx_q.size(), 16);
    for (int i = 0; i < 16 && i < rx_q.size(); i++)
      check($sformatf("R3 byte %0d", i), int'(rx_q[i]), 8'h40 + i);

    // R9 transmitter disabled keeps line idle and FIFO intact
    rx_q.delete(); rx_first = 1'b1;
    wr(2'd3, 16'h00C3);
    wr(2'd3, 16'h0011);
    repeat (120) @(negedge clk);
    check("R9 no frames while disabled", rx_q.size(), 0);
    check("R9 line idle", int'(txd), 1);
    drain(ft, dn);
    check("R9 frames after enable", rx_q.size(), 2);
    if (rx_q.size() == 2) begin
      check("R9 byte 0", int'(rx_q[0]), 8'hC3);
      check("R9 byte 1", int'(rx_q[1]), 8'h11);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule